// File: doc/BRIEF.md
# Indirect Parameter Memory Access Bridge

This block gives a host on a serial control bus reach into an internal memory of 512 twelve-bit parameter words without mapping that memory into the host's register space. The host sees four registers: a status register, a read pointer, a write pointer and a data window. To store parameters, the host loads the write pointer once and then writes the data window repeatedly. Each write is forwarded to the internal memory port and the pointer steps forward when the memory acknowledges. To fetch parameters, the host loads the read pointer, which starts a fetch at once. Each later read of the data window returns the fetched word, moves the pointer on and starts the next fetch.

Toward the memory the block drives a simple request/acknowledge port. It carries the address, a write-enable, the write data, and the read data returned with the acknowledge. Only one transfer is ever outstanding. An access that arrives while a transfer is still running is dropped and recorded in a sticky overflow flag. The host sees and clears that flag through the status register.

Top module: `pmb_bridge`

## Requirements
- R1: After reset the status register reads 0 and `mem_req` is low.
- R2: Register select codes are 0 = status, 1 = read pointer, 2 = write pointer, 3 = data window. A pointer write loads bits 8:0 of `host_wdata`, and bits 15:9 are ignored. A pointer read returns the pointer in bits 8:0 with zeros above.
- R3: A data-window write stores `host_wdata[11:0]`, drops bits 15:12 and raises a write request. That request has `mem_we` = 1, `mem_addr` = the write pointer and `mem_wdata` = the stored word.
- R4: On the cycle `mem_ack` answers a write request, the request ends, busy falls and the write pointer increments by one.
- R5: A read-pointer write raises a read request with `mem_we` = 0 at the new pointer. When `mem_ack` answers it, `mem_rdata` is captured into the data window, the request ends and the read pointer is left unchanged.
- R6: A data-window read returns the captured word in bits 11:0 with zeros above. It increments the read pointer and raises a read request at the incremented pointer.
- R7: The status register has bit 0 = write pending, bit 1 = read pending, bit 2 = busy, bit 3 = overflow, and zeros above.
- R8: A request stays asserted, with stable `mem_addr` and `mem_we`, until acknowledged. Busy is high from the cycle after a request is raised until the acknowledge.
- R9: While busy, pointer writes, data-window writes and data-window reads change no state, and a data-window read returns the word already held. Each such access sets the sticky overflow flag. A status read returns the flag and clears it.
- R10: Both pointers wrap from 511 to 0 on increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select (R2 codes) |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word, valid while `host_rd` is high |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | 9 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 12 | Memory read data, valid with `mem_ack` |

## Verification
The assertions assume that the host raises at most one strobe in any cycle. They also assume that `mem_ack` is a single-cycle pulse that appears only while `mem_req` is high, with `mem_rdata` valid in that same cycle. The bench keeps within these limits in two ways. Its host tasks drive exactly one strobe per call. Its memory model pulses the acknowledge for one cycle after a programmable wait, counted only while a request is open. The wait is varied between tests, so busy windows of several lengths are covered. The overflow cases fall inside those windows.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
   typedef enum logic [1:0] {
      SEL_STAT  = 2'd0,
      SEL_RPTR  = 2'd1,
      SEL_WPTR  = 2'd2,
      SEL_DATA  = 2'd3
   } pmb_sel_e;

   localparam int ST_WPEND = 0;
   localparam int ST_RPEND = 1;
   localparam int ST_BUSY  = 2;
   localparam int ST_OVF   = 3;
   localparam int ST_W     = 4;
endpackage

// File: rtl/pmb_ptr.sv
module pmb_ptr #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] PTR_MAX = {AW{1'b1}};

   if (AW < 1) begin : g_bad_aw
      $error("pmb_ptr: AW must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_val;
      else if (step)
         ptr <= ptr + 1'b1;
   end

   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && ptr == PTR_MAX) |=> (ptr == '0));
endmodule

// File: rtl/pmb_xfer.sv
module pmb_xfer (
   input  logic clk,
   input  logic rst_n,
   input  logic attempt,
   input  logic start_wr,
   input  logic start_rd,
   input  logic ovf_clr,
   input  logic mem_ack,
   output logic accept,
   output logic wr_pend,
   output logic rd_pend,
   output logic busy,
   output logic ovf,
   output logic done_wr,
   output logic done_rd
);
   assign busy    = wr_pend | rd_pend;
   assign accept  = attempt & ~busy;
   assign done_wr = wr_pend & mem_ack;
   assign done_rd = rd_pend & mem_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_pend <= 1'b0;
         rd_pend <= 1'b0;
      end else if (busy && mem_ack) begin
         wr_pend <= 1'b0;
         rd_pend <= 1'b0;
      end else begin
         if (start_wr) wr_pend <= 1'b1;
         if (start_rd) rd_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (attempt && busy)
         ovf <= 1'b1;
      else if (ovf_clr)
         ovf <= 1'b0;
   end

   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_ack) |=> busy);

   p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (attempt && busy) |=> ovf);

   p_single_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_pend, rd_pend}));
endmodule

// File: rtl/pmb_rdmux.sv
module pmb_rdmux #(
   parameter int AW      = 9,
   parameter int DW      = 12,
   parameter int BW      = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             sel,
   input  logic                   rd,
   input  logic [pmb_pkg::ST_W-1:0] status,
   input  logic [AW-1:0]          rptr,
   input  logic [AW-1:0]          wptr,
   input  logic [DW-1:0]          data,
   output logic [BW-1:0]          rdata
);
   import pmb_pkg::*;

   logic [BW-1:0] word;

   always_comb begin
      word = '0;
      case (pmb_sel_e'(sel))
         SEL_STAT: word[ST_W-1:0] = status;
         SEL_RPTR: word[AW-1:0]   = rptr;
         SEL_WPTR: word[AW-1:0]   = wptr;
         SEL_DATA: word[DW-1:0]   = data;
         default:  word = '0;
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata <= '0;
         else if (rd)
            rdata <= word;
      end
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n ^ rd;
      assign rdata = word;
   end
endmodule

// File: rtl/pmb_bridge.sv
module pmb_bridge #(
   parameter int AW      = 9,
   parameter int DW      = 12,
   parameter int BW      = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    host_sel,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [BW-1:0] host_wdata,
   output logic [BW-1:0] host_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);
   import pmb_pkg::*;

   if (BW < DW || BW < AW || BW < ST_W) begin : g_bad_width
      $error("pmb_bridge: BW must hold the data, address and status fields");
   end

   logic          sel_stat, sel_rptr, sel_wptr, sel_data;
   logic          attempt, accept;
   logic          ld_rptr, ld_wptr, data_wr, data_rd;
   logic          wr_pend, rd_pend, busy, ovf, done_wr, done_rd;
   logic [AW-1:0] rptr, wptr;
   logic [DW-1:0] data_q;
   logic          unused_hi;

   assign unused_hi = ^host_wdata[BW-1:DW];

   assign sel_stat = (pmb_sel_e'(host_sel) == SEL_STAT);
   assign sel_rptr = (pmb_sel_e'(host_sel) == SEL_RPTR);
   assign sel_wptr = (pmb_sel_e'(host_sel) == SEL_WPTR);
   assign sel_data = (pmb_sel_e'(host_sel) == SEL_DATA);

   assign attempt = (host_wr && !sel_stat) || (host_rd && sel_data);
   assign ld_rptr = accept && host_wr && sel_rptr;
   assign ld_wptr = accept && host_wr && sel_wptr;
   assign data_wr = accept && host_wr && sel_data;
   assign data_rd = accept && host_rd && sel_data;

   pmb_xfer u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .attempt  (attempt),
      .start_wr (data_wr),
      .start_rd (ld_rptr | data_rd),
      .ovf_clr  (host_rd && sel_stat),
      .mem_ack  (mem_ack),
      .accept   (accept),
      .wr_pend  (wr_pend),
      .rd_pend  (rd_pend),
      .busy     (busy),
      .ovf      (ovf),
      .done_wr  (done_wr),
      .done_rd  (done_rd)
   );

   pmb_ptr #(.AW(AW)) u_rptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_rptr),
      .load_val (host_wdata[AW-1:0]),
      .step     (data_rd),
      .ptr      (rptr)
   );

   pmb_ptr #(.AW(AW)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_wptr),
      .load_val (host_wdata[AW-1:0]),
      .step     (done_wr),
      .ptr      (wptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         data_q <= '0;
      else if (data_wr)
         data_q <= host_wdata[DW-1:0];
      else if (done_rd)
         data_q <= mem_rdata;
   end

   assign mem_req   = busy;
   assign mem_we    = wr_pend;
   assign mem_addr  = wr_pend ? wptr : rptr;
   assign mem_wdata = data_q;

   pmb_rdmux #(.AW(AW), .DW(DW), .BW(BW), .OUT_REG(OUT_REG)) u_rdmux (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (host_sel),
      .rd     (host_rd),
      .status ({ovf, busy, rd_pend, wr_pend}),
      .rptr   (rptr),
      .wptr   (wptr),
      .data   (data_q),
      .rdata  (host_rdata)
   );

   p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && mem_ack) |=> (wptr == $past(wptr) + 1'b1));

   p_ack_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> !mem_req);

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend && mem_ack) |=> (data_q == $past(mem_rdata)));

   p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/sim_pmb_bridge.sv
module sim_pmb_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        mem_req, mem_we;
   logic [8:0]  mem_addr;
   logic [11:0] mem_wdata;
   logic        mem_ack;
   logic [11:0] mem_rdata;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int cnt = 0;
   bit finished = 1'b0;
   logic [11:0] model [512];

   always #5 clk = ~clk;

   pmb_bridge u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [11:0] seed(int k);
      return 12'((k * 37 + 5) & 12'hFFF);
   endfunction

   assign mem_rdata = mem_ack ? model[mem_addr] : 12'h000;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         cnt <= 0;
         for (int k = 0; k < 512; k++) model[k] <= seed(k);
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         if (mem_req && mem_we) model[mem_addr] <= mem_wdata;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            mem_ack <= 1'b1;
            cnt <= 0;
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] s, input logic [15:0] v);
      @(negedge clk);
      host_sel = s; host_wdata = v; host_wr = 1'b1;
      @(posedge clk);
      #1 host_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      host_sel = s; host_rd = 1'b1;
      #1 v = host_rdata;
      @(posedge clk);
      #1 host_rd = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      while (mem_req) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      @(negedge clk);
      chk(mem_req == 1'b0, "R1 req", int'(mem_req), 0);
      hread(2'd0, v);
      chk(v == 16'h0000, "R1 status", int'(v), 0);
   endtask

   task automatic t_read();
      logic [15:0] v;
      lat = 3;
      hwrite(2'd1, 16'd10);
      @(negedge clk);
      chk(mem_req && !mem_we && mem_addr == 9'd10, "R5 port", int'(mem_addr), 10);
      hread(2'd0, v);
      chk(v == 16'h0006, "R7 read pending", int'(v), 6);
      idle();
      hread(2'd1, v);
      chk(v == 16'd10, "R5 pointer held", int'(v), 10);
      hread(2'd3, v);
      chk(v == {4'h0, seed(10)}, "R5 R6 first word", int'(v), int'(seed(10)));
      idle();
      hread(2'd1, v);
      chk(v == 16'd11, "R6 pointer step", int'(v), 11);
      hread(2'd3, v);
      chk(v == {4'h0, seed(11)}, "R6 prefetched word", int'(v), int'(seed(11)));
      idle();
   endtask

   task automatic t_write();
      logic [15:0] v;
      lat = 1;
      hwrite(2'd2, 16'd5);
      hwrite(2'd3, 16'h0123);
      @(negedge clk);
      chk(mem_req && mem_we && mem_addr == 9'd5 && mem_wdata == 12'h123,
          "R3 port", int'(mem_wdata), 'h123);
      hread(2'd0, v);
      chk(v == 16'h0005, "R7 write pending", int'(v), 5);
      idle();
      hwrite(2'd3, 16'h0456); idle();
      hwrite(2'd3, 16'h0789); idle();
      chk(model[5] == 12'h123, "R3 word 5", int'(model[5]), 'h123);
      chk(model[6] == 12'h456, "R4 word 6", int'(model[6]), 'h456);
      chk(model[7] == 12'h789, "R4 word 7", int'(model[7]), 'h789);
      hread(2'd2, v);
      chk(v == 16'd8, "R4 pointer", int'(v), 8);
   endtask

   task automatic t_reserved();
      logic [15:0] v;
      lat = 0;
      hwrite(2'd2, 16'hFE03);
      hread(2'd2, v);
      chk(v == 16'h0003, "R2 upper bits dropped", int'(v), 3);
      hwrite(2'd3, 16'hFABC);
      idle();
      chk(model[3] == 12'hABC, "R3 data width", int'(model[3]), 'hABC);
      hread(2'd3, v);
      chk(v == 16'h0ABC, "R6 zero upper", int'(v), 'hABC);
      idle();
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      lat = 2;
      hwrite(2'd2, 16'd511);
      hwrite(2'd3, 16'h0A11); idle();
      hwrite(2'd3, 16'h0B00); idle();
      chk(model[511] == 12'hA11, "R10 write 511", int'(model[511]), 'hA11);
      chk(model[0] == 12'hB00, "R10 write wrap", int'(model[0]), 'hB00);
      hread(2'd2, v);
      chk(v == 16'd1, "R10 write pointer", int'(v), 1);
      hwrite(2'd1, 16'd511); idle();
      hread(2'd3, v);
      chk(v == 16'h0A11, "R10 read 511", int'(v), 'hA11);
      idle();
      hread(2'd3, v);
      chk(v == 16'h0B00, "R10 read wrap", int'(v), 'hB00);
      idle();
      hread(2'd1, v);
      chk(v == 16'd1, "R10 read pointer", int'(v), 1);
   endtask

   task automatic t_overflow();
      logic [15:0] v;
      logic [8:0]  a0;
      lat = 4;
      hwrite(2'd2, 16'd20);
      hwrite(2'd3, 16'h0AAA);
      @(negedge clk);
      a0 = mem_addr;
      @(negedge clk);
      chk(mem_req && mem_addr == a0 && mem_we, "R8 request held", int'(mem_addr), int'(a0));
      hwrite(2'd3, 16'h0BBB);
      hwrite(2'd2, 16'd40);
      idle();
      chk(model[20] == 12'hAAA, "R9 first kept", int'(model[20]), 'hAAA);
      chk(model[21] == seed(21), "R9 second dropped", int'(model[21]), int'(seed(21)));
      hread(2'd2, v);
      chk(v == 16'd21, "R9 pointer untouched", int'(v), 21);
      hread(2'd0, v);
      chk(v == 16'h0008, "R9 flag set", int'(v), 8);
      hread(2'd0, v);
      chk(v == 16'h0000, "R9 flag cleared", int'(v), 0);
      hwrite(2'd1, 16'd30);
      hread(2'd3, v);
      chk(v == 16'h0AAA, "R9 read while busy", int'(v), 'hAAA);
      idle();
      hread(2'd1, v);
      chk(v == 16'd30, "R9 read pointer untouched", int'(v), 30);
      hread(2'd0, v);
      chk(v == 16'h0008, "R9 flag from read", int'(v), 8);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_read();
      t_write();
      t_reserved();
      t_wrap();
      t_overflow();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule